// File: doc/BRIEF.md
# Cross-Port Mailbox Doorbell

This block raises a doorbell interrupt between the two sides of a shared two-port memory. Each side owns one mailbox word at the very top of the address space: the left side owns the all-ones-minus-one address and the right side owns the all-ones address. A write by the opposite side into a mailbox raises the owner's interrupt. A read of that mailbox by the owner drops it again. The mailbox bytes live in the ordinary memory array and never pass through this block. The block only watches each side's access strobes and drives one active-low interrupt line per side.

Every strobe is sampled on the rising clock edge, and the interrupt output reflects the access one cycle later. An access is only counted when the side doing it is not held off by its busy input, which is active low. A build-time switch removes the feature entirely. The two top addresses then serve as plain storage, and both interrupt lines stay inactive.

Top module: `mbox_irq`

## Requirements
- R1: While reset is asserted and right after it is released, both `lt_irq_n` and `rt_irq_n` are 1 (inactive).
- R2: A right-side write (`rt_sel`=1, `rt_wr`=1, `rt_busy_n`=1) to address 2^ADDR_W-2 drives `lt_irq_n` to 0 from the next clock edge on.
- R3: A left-side read (`lt_sel`=1, `lt_wr`=0, `lt_oe`=1, `lt_busy_n`=1) of address 2^ADDR_W-2 returns `lt_irq_n` to 1 at the next edge, provided no set occurs in the same cycle.
- R4: A left-side write to address 2^ADDR_W-1 drives `rt_irq_n` to 0. A right-side read of 2^ADDR_W-1, with the same strobe conditions as R3, returns it to 1.
- R5: An access whose own side has its busy input at 0 neither sets nor clears any interrupt.
- R6: If a set and a clear of the same interrupt fall in one cycle, the set wins and the interrupt is active afterwards.
- R7: None of these affects either interrupt: a write by a side to its own mailbox, a read of a mailbox by the opposite side, a read with `lt_oe`/`rt_oe` at 0, an access with the select at 0, or an access to any other address.
- R8: With `MBOX_EN`=0, both interrupt outputs stay at 1 whatever the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_addr | input | ADDR_W | Left-side address |
| lt_sel | input | 1 | Left-side memory select, active high |
| lt_wr | input | 1 | Left-side write strobe (1 write, 0 read) |
| lt_oe | input | 1 | Left-side output enable, active high |
| lt_busy_n | input | 1 | Left-side busy, 0 blocks the access |
| rt_addr | input | ADDR_W | Right-side address |
| rt_sel | input | 1 | Right-side memory select, active high |
| rt_wr | input | 1 | Right-side write strobe (1 write, 0 read) |
| rt_oe | input | 1 | Right-side output enable, active high |
| rt_busy_n | input | 1 | Right-side busy, 0 blocks the access |
| lt_irq_n | output | 1 | Left-side interrupt, active low |
| rt_irq_n | output | 1 | Right-side interrupt, active low |

## Verification
The bench builds the main instance with ADDR_W=6, which puts the mailboxes at 62 and 63. At that width, neighbouring addresses such as 61 and 0 can be hit directly, so address-match mistakes show up within a few cycles. A second instance with MBOX_EN=0 receives the same stimulus and must keep both lines high. Both instances are compared on every cycle against a behavioural model. That comparison covers busy blocking, simultaneous set and clear, and the cross-side cases.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  // Decoded accesses of one side in the current cycle
  typedef struct packed {
    logic wr_peer;  // write into the opposite side's mailbox
    logic rd_own;   // read of this side's own mailbox
  } side_hits_t;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/mbox_side_dec.sv
module mbox_side_dec
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter bit          IS_RIGHT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel,
  input  logic              wr,
  input  logic              oe,
  input  logic              busy_n,
  output side_hits_t        hits
);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LEFT_BOX  = TOP_ADDR - 1'b1;
  localparam logic [ADDR_W-1:0] OWN_BOX   = IS_RIGHT ? TOP_ADDR : LEFT_BOX;
  localparam logic [ADDR_W-1:0] PEER_BOX  = IS_RIGHT ? LEFT_BOX : TOP_ADDR;

  logic granted;
  logic wr_cyc;
  logic rd_cyc;

  always_comb begin
    granted      = sel & busy_n;
    wr_cyc       = granted & wr;
    rd_cyc       = granted & ~wr & oe;
    hits.wr_peer = wr_cyc & (addr == PEER_BOX);
    hits.rd_own  = rd_cyc & (addr == OWN_BOX);
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  generate
    if (ENABLE) begin : g_live
      logic pend_q;
      logic pend_d;
      logic pend_ce;

      always_comb begin
        pend_ce = set_req | clr_req;
        pend_d  = set_req;  // set has priority over clear
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
        end else if (pend_ce) begin
          pend_q <= pend_d;
        end
      end

      assign irq_n = ~pend_q;
    end else begin : g_off
      logic unused_req;
      assign unused_req = set_req ^ clr_req ^ clk ^ rst_n;
      assign irq_n      = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter bit          MBOX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              lt_sel,
  input  logic              lt_wr,
  input  logic              lt_oe,
  input  logic              lt_busy_n,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_sel,
  input  logic              rt_wr,
  input  logic              rt_oe,
  input  logic              rt_busy_n,
  output logic              lt_irq_n,
  output logic              rt_irq_n
);
  logic [ADDR_W-1:0] s_addr   [NUM_SIDES];
  logic              s_sel    [NUM_SIDES];
  logic              s_wr     [NUM_SIDES];
  logic              s_oe     [NUM_SIDES];
  logic              s_busy_n [NUM_SIDES];
  side_hits_t        s_hits   [NUM_SIDES];
  logic              s_irq_n  [NUM_SIDES];

  always_comb begin
    s_addr[0] = lt_addr;  s_addr[1] = rt_addr;
    s_sel[0]  = lt_sel;   s_sel[1]  = rt_sel;
    s_wr[0]   = lt_wr;    s_wr[1]   = rt_wr;
    s_oe[0]   = lt_oe;    s_oe[1]   = rt_oe;
    s_busy_n[0] = lt_busy_n;
    s_busy_n[1] = rt_busy_n;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SIDES; gi++) begin : g_side
      mbox_side_dec #(
        .ADDR_W   (ADDR_W),
        .IS_RIGHT (gi == 1)
      ) u_dec (
        .addr   (s_addr[gi]),
        .sel    (s_sel[gi]),
        .wr     (s_wr[gi]),
        .oe     (s_oe[gi]),
        .busy_n (s_busy_n[gi]),
        .hits   (s_hits[gi])
      );

      // set comes from the opposite side, clear from the owner
      mbox_flag #(
        .ENABLE (MBOX_EN)
      ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (s_hits[NUM_SIDES-1-gi].wr_peer),
        .clr_req (s_hits[gi].rd_own),
        .irq_n   (s_irq_n[gi])
      );
    end
  endgenerate

  assign lt_irq_n = s_irq_n[0];
  assign rt_irq_n = s_irq_n[1];
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
  parameter int unsigned ADDR_W  = 14,
  parameter bit          MBOX_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lt_addr,
  input logic              lt_sel,
  input logic              lt_wr,
  input logic              lt_oe,
  input logic              lt_busy_n,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              rt_sel,
  input logic              rt_wr,
  input logic              rt_oe,
  input logic              rt_busy_n,
  input logic              lt_irq_n,
  input logic              rt_irq_n
);
  localparam logic [ADDR_W-1:0] HI_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LO_BOX = HI_BOX - 1'b1;
  localparam bit                ON     = MBOX_EN;

  logic ring_left, ring_right, ack_left, ack_right;
  assign ring_left  = rt_sel && rt_wr && rt_busy_n && (rt_addr == LO_BOX);
  assign ring_right = lt_sel && lt_wr && lt_busy_n && (lt_addr == HI_BOX);
  assign ack_left   = lt_sel && !lt_wr && lt_oe && lt_busy_n && (lt_addr == LO_BOX);
  assign ack_right  = rt_sel && !rt_wr && rt_oe && rt_busy_n && (rt_addr == HI_BOX);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (lt_irq_n && rt_irq_n));

  // R2
  ring_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ON && ring_left) |=> !lt_irq_n);

  // R4
  ring_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ON && ring_right) |=> !rt_irq_n);

  // R3
  ack_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_left && !ring_left) |=> lt_irq_n);

  // R4
  ack_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_right && !ring_right) |=> rt_irq_n);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_busy_n && !rt_busy_n) |=> ($stable(lt_irq_n) && $stable(rt_irq_n)));

  // R8
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ON |-> (lt_irq_n && rt_irq_n));
endmodule

bind mbox_irq mbox_irq_chk #(
  .ADDR_W  (ADDR_W),
  .MBOX_EN (MBOX_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lt_addr   (lt_addr),
  .lt_sel    (lt_sel),
  .lt_wr     (lt_wr),
  .lt_oe     (lt_oe),
  .lt_busy_n (lt_busy_n),
  .rt_addr   (rt_addr),
  .rt_sel    (rt_sel),
  .rt_wr     (rt_wr),
  .rt_oe     (rt_oe),
  .rt_busy_n (rt_busy_n),
  .lt_irq_n  (lt_irq_n),
  .rt_irq_n  (rt_irq_n)
);

// File: tb/tb_mbox_irq.sv
`timescale 1ns/1ps
module tb_mbox_irq;
  localparam int AW = 6;
  localparam int LBOX = (1 << AW) - 2;  // 62
  localparam int RBOX = (1 << AW) - 1;  // 63

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_sel = 0, lt_wr = 0, lt_oe = 0, lt_busy_n = 1;
  logic rt_sel = 0, rt_wr = 0, rt_oe = 0, rt_busy_n = 1;
  logic lt_irq_n, rt_irq_n, off_lt_irq_n, off_rt_irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";
  int m_lt = 1, m_rt = 1;  // model levels of the two lines

  always #10 clk = ~clk;

  mbox_irq #(.ADDR_W(AW), .MBOX_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(lt_addr), .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_busy_n(lt_busy_n),
    .rt_addr(rt_addr), .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_busy_n(rt_busy_n),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n));

  mbox_irq #(.ADDR_W(AW), .MBOX_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(lt_addr), .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_busy_n(lt_busy_n),
    .rt_addr(rt_addr), .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_busy_n(rt_busy_n),
    .lt_irq_n(off_lt_irq_n), .rt_irq_n(off_rt_irq_n));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lt = 1; m_rt = 1;
    end else begin
      bit ls, lc, rs, rc;
      ls = rt_sel && rt_wr && rt_busy_n && (int'(rt_addr) == LBOX);
      lc = lt_sel && !lt_wr && lt_oe && lt_busy_n && (int'(lt_addr) == LBOX);
      rs = lt_sel && lt_wr && lt_busy_n && (int'(lt_addr) == RBOX);
      rc = rt_sel && !rt_wr && rt_oe && rt_busy_n && (int'(rt_addr) == RBOX);
      if (ls) m_lt = 0; else if (lc) m_lt = 1;
      if (rs) m_rt = 0; else if (rc) m_rt = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check({phase, " model lt"}, lt_irq_n, m_lt);
      check({phase, " model rt"}, rt_irq_n, m_rt);
      check("R8 off lt", off_lt_irq_n, 1);
      check("R8 off rt", off_rt_irq_n, 1);
    end
  end

  task automatic idle();
    lt_sel = 0; lt_wr = 0; lt_oe = 0; lt_busy_n = 1; lt_addr = '0;
    rt_sel = 0; rt_wr = 0; rt_oe = 0; rt_busy_n = 1; rt_addr = '0;
  endtask

  // one side access: side 0 left, 1 right; kind 1 write, 0 read
  task automatic put(input int side, input int a, input bit wr, input bit oe, input bit bsy_n);
    if (side == 0) begin
      lt_sel = 1; lt_addr = AW'(a); lt_wr = wr; lt_oe = oe; lt_busy_n = bsy_n;
    end else begin
      rt_sel = 1; rt_addr = AW'(a); rt_wr = wr; rt_oe = oe; rt_busy_n = bsy_n;
    end
  endtask

  // apply driven inputs for one edge, then return to idle after it
  task automatic tick();
    @(posedge clk); #5; idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #5;
    check("R1 lt in reset", lt_irq_n, 1);
    check("R1 rt in reset", rt_irq_n, 1);
    rst_n = 1;
    @(posedge clk); #5;
    check("R1 lt after reset", lt_irq_n, 1);
    check("R1 rt after reset", rt_irq_n, 1);

    phase = "R2";
    put(1, LBOX, 1, 0, 1); tick();
    check("R2 lt set", lt_irq_n, 0);
    check("R2 rt untouched", rt_irq_n, 1);

    phase = "R7";
    put(0, LBOX, 1, 1, 1); tick();            // own-box write
    check("R7 own write lt", lt_irq_n, 0);
    put(1, LBOX, 0, 1, 1); tick();            // peer reads left box
    check("R7 peer read lt", lt_irq_n, 0);
    put(0, LBOX, 0, 0, 1); tick();            // no output enable
    check("R7 no oe lt", lt_irq_n, 0);
    put(0, LBOX - 1, 0, 1, 1); tick();        // neighbour address
    check("R7 addr 61 lt", lt_irq_n, 0);
    put(0, RBOX, 0, 1, 1); tick();            // left reads right box
    check("R7 read 63 lt", lt_irq_n, 0);
    check("R7 read 63 rt", rt_irq_n, 1);
    put(1, RBOX, 1, 0, 1); tick();            // right writes own box
    check("R7 own write rt", rt_irq_n, 1);
    put(1, 0, 1, 0, 1); tick();
    check("R7 addr 0 lt", lt_irq_n, 0);

    phase = "R3";
    put(0, LBOX, 0, 1, 1); tick();
    check("R3 lt cleared", lt_irq_n, 1);

    phase = "R4";
    put(0, RBOX, 1, 0, 1); tick();
    check("R4 rt set", rt_irq_n, 0);
    check("R4 lt stays", lt_irq_n, 1);
    put(1, RBOX, 0, 1, 1); tick();
    check("R4 rt cleared", rt_irq_n, 1);

    phase = "R5";
    put(1, LBOX, 1, 0, 0); tick();
    check("R5 blocked set lt", lt_irq_n, 1);
    put(0, RBOX, 1, 0, 0); tick();
    check("R5 blocked set rt", rt_irq_n, 1);
    put(1, LBOX, 1, 0, 1); put(0, RBOX, 1, 0, 1); tick();
    check("R5 both set lt", lt_irq_n, 0);
    check("R5 both set rt", rt_irq_n, 0);
    put(0, LBOX, 0, 1, 0); tick();
    check("R5 blocked clear lt", lt_irq_n, 0);
    put(1, RBOX, 0, 1, 0); tick();
    check("R5 blocked clear rt", rt_irq_n, 0);

    phase = "R6";
    put(0, LBOX, 0, 1, 1); put(1, LBOX, 1, 0, 1); tick();
    check("R6 set wins held lt", lt_irq_n, 0);
    put(0, LBOX, 0, 1, 1); tick();
    check("R6 clear lt", lt_irq_n, 1);
    put(0, LBOX, 0, 1, 1); put(1, LBOX, 1, 0, 1); tick();
    check("R6 set wins from idle lt", lt_irq_n, 0);
    put(1, RBOX, 0, 1, 1); put(0, RBOX, 1, 0, 1); tick();
    check("R6 set wins rt", rt_irq_n, 0);

    phase = "R1";
    rst_n = 0; #2;
    check("R1 async reset lt", lt_irq_n, 1);
    check("R1 async reset rt", rt_irq_n, 1);
    @(posedge clk); #5; rst_n = 1;
    repeat (2) @(posedge clk); #5;

    phase = "R8";
    check("R8 off lt end", off_lt_irq_n, 1);
    check("R8 off rt end", off_rt_irq_n, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule